// File: doc/BRIEF.md
# Dual-Table Harmonic-Elimination PWM Generator

This block turns a commanded fundamental frequency into three-level switching-state commands for the three legs of an inverter. A phase accumulator advances by a frequency control word on every clock. Each leg's level is read from a table of nine precomputed switching angles that cover one quarter of the fundamental. The remaining three quarters follow from quarter-wave symmetry: the second quarter mirrors the first, and the negative half cycle is the sign-inverted copy of the positive half.

Two angle tables are held. One is a conventional set, used at or above a frequency threshold (typically nine tenths of rated frequency). The other is a modified set that suppresses triplen harmonics, used below the threshold. When the commanded frequency crosses the threshold, the new table is not applied at once. The change waits until the phase accumulator wraps, which is a positive-going zero crossing of the phase-a fundamental at the end of a full cycle. All three legs then change tables on the same clock. Angles are loaded through a simple write port. Only the table not currently in use can be written, and a write that breaks ascending order raises a sticky flag.

Top module: `dual_table_she_pwm`

## Requirements
- R1: While reset is asserted at a clock edge, all three legs output level 0, `order_err` is 0, and `mode_o` is set directly from the threshold comparison, with no wait for a zero crossing.
- R2: Leg codes are 2-bit two's complement: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. The code 2'b10 never appears.
- R3: The 32-bit accumulator adds `fcw` on every clock. When phase bit 31 is 0, let x be bits 29:0 if bit 30 is 0, and the complement of bits 29:0 if bit 30 is 1. A leg is +1 when an odd number of the active table's angles are less than or equal to x, and 0 otherwise. The leg output shows the phase of the previous clock.
- R4: When phase bit 31 is 1, the same count rule gives -1 for an odd count and 0 for an even count.
- R5: Leg a uses the accumulator phase. Leg b uses the phase minus 32'h55555555, and leg c uses the phase minus 32'hAAAAAAAA. All three legs use the same active table.
- R6: The selected table is the conventional one (`mode_o` = 0) when `fcw` >= `thresh`, and the modified one (`mode_o` = 1) otherwise.
- R7: After reset, `mode_o` changes only on the clock edge at which the accumulator addition carries out of bit 31 (phase wrap). The new table is used from the next phase onward.
- R8: A write whose `wr_tbl` equals the current `mode_o` is ignored. It changes neither table contents nor `order_err`.
- R9: An accepted write stores `wr_angle` at entry `wr_idx` (0..8) of table `wr_tbl` (0 = conventional, 1 = modified). If `wr_idx` > 0 and `wr_angle` <= the stored entry `wr_idx`-1, `order_err` is set one clock later and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcw | input | 32 | Frequency control word added to the phase each clock |
| thresh | input | 32 | Changeover threshold in fcw units |
| wr_en | input | 1 | Angle write strobe |
| wr_tbl | input | 1 | Target table: 0 conventional, 1 modified |
| wr_idx | input | 4 | Angle index 0..8 |
| wr_angle | input | 30 | Angle in quarter-cycle units |
| leg_a | output | 2 | Phase-a level code |
| leg_b | output | 2 | Phase-b level code |
| leg_c | output | 2 | Phase-c level code |
| mode_o | output | 1 | Table in use: 0 conventional, 1 modified |
| order_err | output | 1 | Sticky out-of-order write flag |

## Verification
The leg levels appear one clock after the phase they are computed from. A `mode_o` change appears on the edge where the phase wraps, so the first level drawn from the new table shows one clock after that. `order_err` rises one clock after the offending write. The bench keeps its own phase, mode and table state, and advances that state on the same edges with the same one-register delay. It compares every output at the falling edge that follows. Explicit checks are placed in the exact cycles around reset, an ignored write, a deferred changeover and an out-of-order write.

// File: rtl/she_pwm_pkg.sv
// Shared encodings for the dual-table harmonic-elimination PWM generator.
// Assumes two's complement 2-bit leg codes and a one-bit table select.
package she_pwm_pkg;
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } lvl_e;

    typedef enum logic {
        MODE_CONV = 1'b0,
        MODE_MOD  = 1'b1
    } mode_e;
endpackage

// File: rtl/she_phase_acc.sv
// Fundamental phase accumulator. Adds the frequency word each clock and
// flags the carry out of the top bit (one full cycle completed).
// Assumes fcw below half the range so that a wrap is one zero crossing.
module she_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] fcw,
    output logic [ACC_W-1:0] phase,
    output logic             wrap
);
    logic [ACC_W:0] sum;

    // Next phase with carry.
    always_comb begin
        sum  = {1'b0, phase} + {1'b0, fcw};
        wrap = sum[ACC_W];
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/she_angle_bank.sv
// Two switching-angle tables with a write port. Only the inactive table
// accepts writes. An out-of-order write raises a sticky error flag.
// Assumes tables are loaded while the other table drives the legs.
module she_angle_bank #(
    parameter int N_ANG = 9,
    parameter int ANG_W = 30,
    parameter int IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active_sel,
    input  logic                        wr_en,
    input  logic                        wr_tbl,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ANG_W-1:0]            wr_angle,
    output logic [N_ANG-1:0][ANG_W-1:0] angles_act,
    output logic                        order_err
);
    logic [ANG_W-1:0] tbl [2][N_ANG];
    logic             in_range, accept, bad_order;
    logic [IDX_W-1:0] prev_idx;

    // Write acceptance and ordering test against the preceding entry.
    always_comb begin
        in_range  = int'(wr_idx) < N_ANG;
        accept    = wr_en && (wr_tbl != active_sel) && in_range;
        prev_idx  = (wr_idx == '0 || !in_range) ? '0 : wr_idx - 1'b1;
        bad_order = accept && (wr_idx != '0) && (wr_angle <= tbl[wr_tbl][prev_idx]);
    end

    // Table storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 2; t++)
                for (int k = 0; k < N_ANG; k++)
                    tbl[t][k] <= '0;
        end else if (accept) begin
            tbl[wr_tbl][wr_idx] <= wr_angle;
        end
    end

    // Sticky ordering error.
    always_ff @(posedge clk) begin
        if (!rst_n)         order_err <= 1'b0;
        else if (bad_order) order_err <= 1'b1;
    end

    for (genvar k = 0; k < N_ANG; k++) begin : g_act
        assign angles_act[k] = tbl[active_sel][k];
    end
endmodule

// File: rtl/she_leg_shaper.sv
// One inverter leg. Folds the phase into a quarter-cycle position, counts
// the angles at or below it, and registers the signed three-level code.
// Assumes angles are ascending, so the count parity is the toggle state.
module she_leg_shaper
    import she_pwm_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int N_ANG = 9,
    localparam int ANG_W = ACC_W - 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ACC_W-1:0]            phase,
    input  logic [N_ANG-1:0][ANG_W-1:0] angles,
    output lvl_e                        lvl
);
    logic [ANG_W-1:0] pos;
    logic [N_ANG-1:0] hits;
    lvl_e             lvl_next;

    // Mirror odd quarters onto the first quarter.
    always_comb pos = phase[ACC_W-2] ? ~phase[ANG_W-1:0] : phase[ANG_W-1:0];

    for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
        assign hits[k] = angles[k] <= pos;
    end

    // Odd crossings give the half-cycle polarity, even give zero.
    always_comb begin
        if (!(^hits))             lvl_next = LVL_ZERO;
        else if (phase[ACC_W-1])  lvl_next = LVL_NEG;
        else                      lvl_next = LVL_POS;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= LVL_ZERO;
        else        lvl <= lvl_next;
    end
endmodule

// File: rtl/dual_table_she_pwm.sv
// Top level: phase accumulator, two angle tables, three leg shapers and
// the table-select register, which changes only at a phase-a wrap.
// Assumes fcw and thresh are quasi-static relative to the fundamental.
module dual_table_she_pwm
    import she_pwm_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int N_ANG = 9,
    localparam int ANG_W = ACC_W - 2,
    localparam int IDX_W = $clog2(N_ANG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] fcw,
    input  logic [ACC_W-1:0] thresh,
    input  logic             wr_en,
    input  logic             wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ANG_W-1:0] wr_angle,
    output logic [1:0]       leg_a,
    output logic [1:0]       leg_b,
    output logic [1:0]       leg_c,
    output logic             mode_o,
    output logic             order_err
);
    localparam logic [ACC_W-1:0] THIRD = ACC_W'((65'd1 << ACC_W) / 65'd3);
    localparam int N_LEG = 3;

    logic [ACC_W-1:0]            phase_a;
    logic                        acc_wrap;
    mode_e                       mode_q, mode_want;
    logic [N_ANG-1:0][ANG_W-1:0] angles_act;
    lvl_e                        lvl_w [N_LEG];

    she_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .fcw   (fcw),
        .phase (phase_a),
        .wrap  (acc_wrap)
    );

    // Threshold decision.
    always_comb mode_want = (fcw >= thresh) ? MODE_CONV : MODE_MOD;

    // Table select: direct in reset, otherwise only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_wrap) mode_q <= mode_want;
    end

    she_angle_bank #(.N_ANG(N_ANG), .ANG_W(ANG_W), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_sel (mode_q),
        .wr_en      (wr_en),
        .wr_tbl     (wr_tbl),
        .wr_idx     (wr_idx),
        .wr_angle   (wr_angle),
        .angles_act (angles_act),
        .order_err  (order_err)
    );

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        localparam logic [ACC_W-1:0] OFS = ACC_W'(64'(g) * 64'(THIRD));
        logic [ACC_W-1:0] leg_phase;
        assign leg_phase = phase_a - OFS;
        she_leg_shaper #(.ACC_W(ACC_W), .N_ANG(N_ANG)) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .phase  (leg_phase),
            .angles (angles_act),
            .lvl    (lvl_w[g])
        );
    end

    assign leg_a  = lvl_w[0];
    assign leg_b  = lvl_w[1];
    assign leg_c  = lvl_w[2];
    assign mode_o = mode_q;
endmodule

// File: rtl/she_pwm_chk.sv
// Property checker for dual_table_she_pwm, attached by bind.
// Assumes synchronous active-low reset; history is guarded by a reset flag.
module she_pwm_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] phase,
    input logic [ACC_W-1:0] fcw,
    input logic             wrap,
    input logic             mode,
    input logic [1:0]       leg_a,
    input logic [1:0]       leg_b,
    input logic [1:0]       leg_c,
    input logic             order_err
);
    logic in_rst_q = 1'b0;

    // Remembers that the previous edge was a reset edge.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    AST_RESET_LEGS_ZERO: assert property (@(posedge clk)
        in_rst_q |-> (leg_a == 2'b00 && leg_b == 2'b00 && leg_c == 2'b00 && !order_err)); // R1

    AST_LEG_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_a != 2'b10 && leg_b != 2'b10 && leg_c != 2'b10)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase == $past(phase) + $past(fcw)); // R3

    AST_POS_HALF_NO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(phase[ACC_W-1])) |-> leg_a != 2'b11); // R3

    AST_NEG_HALF_NO_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase[ACC_W-1])) |-> leg_a != 2'b01); // R4

    AST_MODE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode != $past(mode)) |-> $past(wrap)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(order_err)) |-> order_err); // R9
endmodule

bind dual_table_she_pwm she_pwm_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_a),
    .fcw       (fcw),
    .wrap      (acc_wrap),
    .mode      (mode_o),
    .leg_a     (leg_a),
    .leg_b     (leg_b),
    .leg_c     (leg_c),
    .order_err (order_err)
);

// File: tb/tb_dual_table_she_pwm.sv
// Directed bench with a cycle model kept from the requirements.
module tb_dual_table_she_pwm;
    localparam logic [31:0] THIRD   = 32'h5555_5555;
    localparam logic [31:0] THR     = 32'h0399_9999;
    localparam logic [31:0] FCW_HI  = 32'h0400_0000;
    localparam logic [31:0] FCW_LO  = 32'h0380_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fcw = FCW_HI;
    logic [31:0] thresh = THR;
    logic        wr_en = 1'b0;
    logic        wr_tbl = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [29:0] wr_angle = '0;
    logic [1:0]  leg_a, leg_b, leg_c;
    logic        mode_o, order_err;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;

    always #4 clk = ~clk;

    dual_table_she_pwm dut (
        .clk(clk), .rst_n(rst_n), .fcw(fcw), .thresh(thresh),
        .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_idx(wr_idx), .wr_angle(wr_angle),
        .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c),
        .mode_o(mode_o), .order_err(order_err)
    );

    // Reference state
    logic [29:0] m_tbl [2][9];
    logic [31:0] m_phase;
    logic        m_mode, m_err;
    logic [1:0]  e_a, e_b, e_c;

    function automatic logic [1:0] ref_lvl(input logic [31:0] p, input logic t);
        logic [29:0] x;
        int n;
        n = 0;
        x = p[30] ? (30'h3FFF_FFFF - p[29:0]) : p[29:0];
        for (int k = 0; k < 9; k++) if (m_tbl[t][k] <= x) n++;
        if (n % 2 == 0) return 2'b00;
        return p[31] ? 2'b11 : 2'b01;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= '0;
            m_mode  <= (fcw < thresh);
            m_err   <= 1'b0;
            e_a <= 2'b00; e_b <= 2'b00; e_c <= 2'b00;
            for (int t = 0; t < 2; t++) for (int k = 0; k < 9; k++) m_tbl[t][k] <= '0;
        end else begin
            e_a <= ref_lvl(m_phase, m_mode);
            e_b <= ref_lvl(m_phase - THIRD, m_mode);
            e_c <= ref_lvl(m_phase - 2 * THIRD, m_mode);
            m_phase <= m_phase + fcw;
            if ({1'b0, m_phase} + {1'b0, fcw} > 33'h0_FFFF_FFFF) m_mode <= (fcw < thresh);
            if (wr_en && wr_tbl != m_mode && wr_idx < 9) begin
                m_tbl[wr_tbl][wr_idx] <= wr_angle;
                if (wr_idx != 0 && wr_angle <= m_tbl[wr_tbl][wr_idx - 1]) m_err <= 1'b1;
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison at the falling edge
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            check_eq("R3 R4 leg_a", {30'd0, leg_a}, {30'd0, e_a});
            check_eq("R5 leg_b", {30'd0, leg_b}, {30'd0, e_b});
            check_eq("R5 leg_c", {30'd0, leg_c}, {30'd0, e_c});
            check_eq("R6 R7 mode_o", {31'd0, mode_o}, {31'd0, m_mode});
            check_eq("R9 order_err", {31'd0, order_err}, {31'd0, m_err});
        end
    end

    task automatic do_reset(input logic [31:0] f);
        @(negedge clk);
        chk_on = 1'b0;
        rst_n = 1'b0;
        fcw = f;
        repeat (3) @(negedge clk);
        check_eq("R1 legs in reset", {26'd0, leg_a, leg_b, leg_c}, 32'd0);
        check_eq("R1 err in reset", {31'd0, order_err}, 32'd0);
        check_eq("R1 R6 mode in reset", {31'd0, mode_o}, {31'd0, (f < THR)});
        rst_n = 1'b1;
        chk_on = 1'b1;
    endtask

    task automatic wr(input logic t, input int idx, input logic [29:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = t; wr_idx = 4'(idx); wr_angle = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(FCW_LO);
        do_reset(FCW_HI);
    endtask

    task automatic t_load_modified;
        for (int k = 0; k < 9; k++) wr(1'b1, k, 30'h0100_0000 + 30'(k) * 30'h0680_0000);
        check_eq("R9 ordered load no err", {31'd0, order_err}, 32'd0);
        repeat (200) @(negedge clk);
    endtask

    task automatic t_active_write_ignored;
        wr(1'b0, 3, 30'd0);
        check_eq("R8 active write no err", {31'd0, order_err}, 32'd0);
        repeat (100) @(negedge clk);
    endtask

    task automatic t_switch_to_modified;
        @(negedge clk);
        fcw = FCW_LO;
        @(negedge clk);
        check_eq("R7 mode held before wrap", {31'd0, mode_o}, 32'd0);
        while (mode_o == 1'b0) @(negedge clk);
        check_eq("R6 modified selected", {31'd0, mode_o}, 32'd1);
        for (int k = 0; k < 9; k++) wr(1'b0, k, 30'(k + 1) * 30'h0600_0000);
        repeat (300) @(negedge clk);
    endtask

    task automatic t_switch_back;
        @(negedge clk);
        fcw = FCW_HI;
        @(negedge clk);
        check_eq("R7 mode held before wrap", {31'd0, mode_o}, 32'd1);
        while (mode_o == 1'b1) @(negedge clk);
        check_eq("R6 conventional selected", {31'd0, mode_o}, 32'd0);
        repeat (300) @(negedge clk);
        fcw = 32'h0123_4567;
        repeat (400) @(negedge clk);
        fcw = FCW_HI;
        repeat (200) @(negedge clk);
    endtask

    task automatic t_order_error;
        while (mode_o != 1'b0) @(negedge clk);
        wr(1'b1, 5, 30'h0000_0010);
        check_eq("R9 out-of-order sets err", {31'd0, order_err}, 32'd1);
        wr(1'b1, 5, 30'h3000_0000);
        check_eq("R9 err sticky", {31'd0, order_err}, 32'd1);
        repeat (50) @(negedge clk);
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_load_modified();
        t_active_write_ignored();
        t_switch_to_modified();
        t_switch_back();
        t_order_error();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule